// File: doc/BRIEF.md
# Pattern-Unlocked Memory Bank Selector

This block sits between a processor's chip-enable strobe and a set of memory banks. Banks are not chosen through a write port. Instead, software performs a run of sixteen reads at chosen addresses, and the block watches a 4-bit address nibble on each of them. When all sixteen nibbles form a fixed unlock sequence, the block latches a new bank number onto four select outputs. It can also switch every bank off.

Every input is brought into the system clock domain through a synchronizer. A strobe cycle starts on the synchronized falling edge of the active-low chip-enable input, which is where the nibble is captured. The cycle is judged on the synchronized rising edge. The outgoing chip enable is gated from the raw incoming strobe without any register in the path. It stays high while the banks are off and follows the strobe otherwise.

Nibble bit 3 is line W, bit 2 is X, bit 1 is Y and bit 0 is Z.

Top module: `bank_unlock_sel`

## Requirements
- R1: After power-up, `bank_sel` is 0000 and `ce_out_n` is held high, even while `ce_in_n` is low.
- R2: A strobe cycle whose nibble is 1111 restarts the sequence, so the next cycle is compared as step 0. A partial sequence followed by a full sequence with no 1111 between them does not unlock.
- R3: Steps 0 to 10 must equal, in WXYZ order: 1010, 0101, 1010, 0101, 0101, 0101, 1010, 1010, 0101, 1010, 0101. Any mismatch, including one on W alone, abandons the attempt and leaves the outputs unchanged.
- R4: At steps 11 to 15 only XYZ is compared, against 010, 010, 010, 101 and 101. A mismatch there also abandons the attempt.
- R5: When W is 1 at step 11, a completed sequence turns the banks off: `bank_sel` becomes 0000 and `ce_out_n` stays high whatever `ce_in_n` does.
- R6: When W is 0 at step 11, the W values of steps 12 to 15 form the bank number, with step 12 as the MSB. This number drives `bank_sel`, whose bit 0 is the LSB. Bank 0 and bank 15 are both valid.
- R7: A new selection appears only after the synchronized rising edge that ends step 15. While step 15 is still low, the outputs keep their old value.
- R8: While a bank is selected, `ce_out_n` equals `ce_in_n`.
- R9: The selected bank holds across any number of ordinary memory cycles until the next complete match.
- R10: While `pfail` is high, the block returns synchronously to the power-up state and clears any partial sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pfail | input | 1 | Power-fail, active-high synchronous reset |
| ce_in_n | input | 1 | Active-low chip enable from the processor |
| addr | input | 4 | Address nibble, WXYZ from bit 3 down to bit 0 |
| bank_sel | output | 4 | Selected bank number, bit 0 is the LSB |
| ce_out_n | output | 1 | Active-low chip enable towards the banks |

## Verification
The assertions assume that every strobe phase, high or low, lasts longer than the synchronizer depth plus one clock. They also assume the nibble is settled before the strobe falls, so the capture edge sees a stable sample. The stimulus keeps to this: it changes the nibble three clocks before each falling edge and holds each strobe phase for six clocks. It asserts `pfail` only between strobe cycles. Because the outputs lag the raw strobe by the synchronizer depth, the per-clock comparison is paused for a few clocks after each strobe rise and after each `pfail` change.

// File: rtl/bank_unlock_pkg.sv
package bank_unlock_pkg;

    localparam int NIB_W       = 4;
    localparam int STEP_CNT    = 16;
    localparam int PTR_W       = $clog2(STEP_CNT);
    localparam int FIXED_STEPS = 11;
    localparam int CTRL_STEP   = FIXED_STEPS;
    localparam int BANK_W      = STEP_CNT - 1 - CTRL_STEP;
    localparam logic [NIB_W-1:0] RESYNC_NIB = '1;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [NIB_W-1:0]  samp;
        logic              off_pend;
        logic [BANK_W-2:0] acc;
        logic [BANK_W-1:0] bank;
        logic              off;
    } sel_state_t;

    // Expected WXYZ value of each step; W is ignored from CTRL_STEP on.
    function automatic logic [NIB_W-1:0] step_expect(input logic [PTR_W-1:0] s);
        case (s)
            4'd0, 4'd2, 4'd6, 4'd7, 4'd9: step_expect = 4'b1010;
            4'd11, 4'd12, 4'd13:          step_expect = 4'b0010;
            default:                      step_expect = 4'b0101;
        endcase
    endfunction

endpackage

// File: rtl/bank_bit_sync.sv
module bank_bit_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg_q[g] <= RST_VAL;
            else     stg_q[g] <= stg_d[g];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/bank_ce_edge.sv
module bank_ce_edge (
    input  logic clk,
    input  logic rst,
    input  logic ce_s,
    output logic fall,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = ce_s;
        fall   = prev_q & ~ce_s;
        rise   = ~prev_q & ce_s;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/bank_step_check.sv
module bank_step_check
    import bank_unlock_pkg::*;
(
    input  logic [PTR_W-1:0] step,
    input  logic [NIB_W-1:0] samp,
    output logic             hit
);
    logic [NIB_W-1:0] want;
    logic [NIB_W-1:0] care;

    always_comb begin
        want = step_expect(step);
        if (int'(step) < FIXED_STEPS) care = '1;
        else                          care = {1'b0, {(NIB_W-1){1'b1}}};
        hit = ((samp ^ want) & care) == '0;
    end
endmodule

// File: rtl/bank_unlock_sel.sv
module bank_unlock_sel
    import bank_unlock_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              pfail,
    input  logic              ce_in_n,
    input  logic [NIB_W-1:0]  addr,
    output logic [BANK_W-1:0] bank_sel,
    output logic              ce_out_n
);
    localparam logic [PTR_W-1:0] LAST_STEP = PTR_W'(STEP_CNT - 1);
    localparam logic [PTR_W-1:0] CTRL_PTR  = PTR_W'(CTRL_STEP);

    logic             ce_s;
    logic [NIB_W-1:0] addr_s;
    logic             ce_fall, ce_rise;
    logic             step_hit;
    sel_state_t       st_d, st_q;

    bank_bit_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ce_sync (
        .clk(clk), .rst(pfail), .d(ce_in_n), .q(ce_s)
    );

    bank_bit_sync #(.W(NIB_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_addr_sync (
        .clk(clk), .rst(pfail), .d(addr), .q(addr_s)
    );

    bank_ce_edge u_edge (
        .clk(clk), .rst(pfail), .ce_s(ce_s), .fall(ce_fall), .rise(ce_rise)
    );

    bank_step_check u_check (
        .step(st_q.ptr), .samp(st_q.samp), .hit(step_hit)
    );

    always_comb begin
        st_d = st_q;
        if (ce_fall) begin
            st_d.samp = addr_s;
        end
        if (ce_rise) begin
            if (st_q.samp == RESYNC_NIB || !step_hit) begin
                st_d.ptr = '0;
            end else if (st_q.ptr == LAST_STEP) begin
                st_d.ptr = '0;
                st_d.off = st_q.off_pend;
                if (st_q.off_pend) st_d.bank = '0;
                else               st_d.bank = {st_q.acc, st_q.samp[NIB_W-1]};
            end else begin
                st_d.ptr = st_q.ptr + PTR_W'(1);
                if (st_q.ptr == CTRL_PTR) begin
                    st_d.off_pend = st_q.samp[NIB_W-1];
                    st_d.acc      = '0;
                end else if (st_q.ptr > CTRL_PTR) begin
                    st_d.acc = {st_q.acc[BANK_W-3:0], st_q.samp[NIB_W-1]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (pfail) begin
            st_q          <= '0;
            st_q.off      <= 1'b1;
            st_q.off_pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_sel = st_q.bank;
    assign ce_out_n = ce_in_n | st_q.off;
endmodule

// File: rtl/bank_unlock_chk.sv
module bank_unlock_chk
    import bank_unlock_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_in_n,
    input logic              ce_out_n,
    input logic [BANK_W-1:0] bank_sel,
    input logic              off,
    input logic [PTR_W-1:0]  ptr,
    input logic              rise,
    input logic [NIB_W-1:0]  samp
);
    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (bank_sel == '0 && ce_out_n)); // R10
    AST_OFF_MASKS_CE: assert property (@(posedge clk) disable iff (rst) off |-> ce_out_n); // R5
    AST_OFF_NO_BANK: assert property (@(posedge clk) disable iff (rst) off |-> bank_sel == '0); // R5
    AST_SEL_ON_LAST_RISE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(bank_sel)) |-> $past(rise && ptr == PTR_W'(STEP_CNT - 1))); // R7
    AST_RESYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rise && samp == RESYNC_NIB) |=> ptr == '0); // R2
    AST_CE_BLOCKED_HIGH: assert property (@(posedge clk) disable iff (rst)
        ce_in_n |-> ce_out_n); // R8
endmodule

bind bank_unlock_sel bank_unlock_chk u_chk (
    .clk(clk), .rst(pfail), .ce_in_n(ce_in_n), .ce_out_n(ce_out_n),
    .bank_sel(bank_sel), .off(st_q.off), .ptr(st_q.ptr), .rise(ce_rise), .samp(st_q.samp)
);

// File: tb/bank_unlock_sel_tb.sv
module bank_unlock_sel_tb;
    logic       clk = 1'b0;
    logic       pfail = 1'b1;
    logic       ce_in_n = 1'b1;
    logic [3:0] addr = 4'h0;
    logic [3:0] bank_sel;
    logic       ce_out_n;

    always #10 clk = ~clk;

    bank_unlock_sel u_dut (
        .clk(clk), .pfail(pfail), .ce_in_n(ce_in_n), .addr(addr),
        .bank_sel(bank_sel), .ce_out_n(ce_out_n)
    );

    int n_chk = 0, n_fail = 0, c_chk = 0, c_fail = 0;
    bit done = 1'b0;

    // Behavioural model: queue of accepted nibbles of the attempt in progress.
    logic [3:0] exp_bank = 4'h0;
    logic       exp_off  = 1'b1;
    logic [3:0] hist[$];
    logic [3:0] code[16] = '{4'hA, 4'h5, 4'hA, 4'h5, 4'h5, 4'h5, 4'hA, 4'hA,
                             4'h5, 4'hA, 4'h5, 4'h2, 4'h2, 4'h2, 4'h5, 4'h5};

    task automatic model_cycle(input logic [3:0] nib);
        logic [3:0] msk;
        int idx;
        if (nib == 4'hF) begin
            hist.delete();
            return;
        end
        hist.push_back(nib);
        idx = hist.size() - 1;
        msk = (idx < 11) ? 4'hF : 4'h7;
        if (((nib ^ code[idx]) & msk) != 4'h0) begin
            hist.delete();
        end else if (hist.size() == 16) begin
            exp_off  = hist[11][3];
            exp_bank = exp_off ? 4'h0 : {hist[12][3], hist[13][3], hist[14][3], hist[15][3]};
            hist.delete();
        end
    endtask

    // Per-clock comparison against the model, paused while outputs settle.
    int   hold = 0;
    logic pce = 1'b1, ppf = 1'b1;
    always @(negedge clk) begin
        if ((ce_in_n && !pce) || (pfail != ppf)) hold = 5;
        pce = ce_in_n;
        ppf = pfail;
        if (hold > 0) begin
            hold--;
        end else if (!done) begin
            c_chk++;
            if (bank_sel !== exp_bank) begin
                c_fail++;
                $display("FAIL R9 per-clock bank actual=%h expected=%h", bank_sel, exp_bank);
            end
            c_chk++;
            if (ce_out_n !== (ce_in_n | exp_off)) begin
                c_fail++;
                $display("FAIL R8 per-clock ce_out_n actual=%b expected=%b", ce_out_n, ce_in_n | exp_off);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc_low(input logic [3:0] nib);
        @(posedge clk); #2 addr = nib;
        repeat (3) @(posedge clk);
        #2 ce_in_n = 1'b0;
        repeat (6) @(posedge clk);
    endtask

    task automatic cyc_high(input logic [3:0] nib);
        #2 ce_in_n = 1'b1;
        model_cycle(nib);
        repeat (6) @(posedge clk);
    endtask

    task automatic cyc(input logic [3:0] nib);
        cyc_low(nib);
        cyc_high(nib);
    endtask

    function automatic logic [3:0] step_nib(input int i, input logic off, input logic [3:0] bank);
        logic [3:0] n;
        n = code[i];
        if (i == 11) n[3] = off;
        else if (i >= 12) n[3] = bank[15 - i];
        return n;
    endfunction

    task automatic unlock(input logic off, input logic [3:0] bank);
        cyc(4'hF);
        for (int i = 0; i < 16; i++) cyc(step_nib(i, off, bank));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + c_chk + 1, n_fail + c_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1 reset bank", bank_sel, 0);
        chk("R1 reset ce_out_n", ce_out_n, 1);
        @(posedge clk); #2 pfail = 1'b0;
        cyc_low(4'h3);
        @(negedge clk);
        chk("R1 ce_out_n blocked at power-up", ce_out_n, 1);
        cyc_high(4'h3);

        unlock(1'b0, 4'hA);
        @(negedge clk);
        chk("R6 bank A", bank_sel, 10);
        cyc_low(4'h3);
        @(negedge clk);
        chk("R8 ce_out_n follows low", ce_out_n, 0);
        cyc_high(4'h3);
        @(negedge clk);
        chk("R8 ce_out_n follows high", ce_out_n, 1);

        // R7: no change while the last step is still low
        cyc(4'hF);
        for (int i = 0; i < 15; i++) cyc(step_nib(i, 1'b0, 4'h5));
        cyc_low(step_nib(15, 1'b0, 4'h5));
        @(negedge clk);
        chk("R7 old bank during last low", bank_sel, 10);
        cyc_high(step_nib(15, 1'b0, 4'h5));
        @(negedge clk);
        chk("R7 new bank after last rise", bank_sel, 5);

        // R3: wrong fixed step (whole nibble), then W only
        cyc(4'hF);
        for (int i = 0; i < 16; i++) cyc(i == 5 ? 4'hA : step_nib(i, 1'b0, 4'hC));
        @(negedge clk);
        chk("R3 mismatch step 5 keeps bank", bank_sel, 5);
        cyc(4'hF);
        for (int i = 0; i < 16; i++) cyc(i == 3 ? 4'hD : step_nib(i, 1'b0, 4'hC));
        @(negedge clk);
        chk("R3 W-only mismatch keeps bank", bank_sel, 5);

        // R4: XYZ wrong at step 13
        cyc(4'hF);
        for (int i = 0; i < 16; i++) cyc(i == 13 ? 4'h3 : step_nib(i, 1'b0, 4'hC));
        @(negedge clk);
        chk("R4 XYZ mismatch keeps bank", bank_sel, 5);
        unlock(1'b0, 4'hC);
        @(negedge clk);
        chk("R4 W free at steps 12-15", bank_sel, 12);

        // R2: partial attempt without resync fails, with resync succeeds
        for (int i = 0; i < 3; i++) cyc(code[i]);
        for (int i = 0; i < 16; i++) cyc(step_nib(i, 1'b0, 4'h6));
        @(negedge clk);
        chk("R2 no resync no unlock", bank_sel, 12);
        for (int i = 0; i < 3; i++) cyc(code[i]);
        unlock(1'b0, 4'h3);
        @(negedge clk);
        chk("R2 resync then unlock", bank_sel, 3);

        // R5: banks off
        unlock(1'b1, 4'h9);
        @(negedge clk);
        chk("R5 off bank", bank_sel, 0);
        cyc_low(4'h3);
        @(negedge clk);
        chk("R5 ce_out_n held high", ce_out_n, 1);
        cyc_high(4'h3);

        // R6: boundary bank numbers
        unlock(1'b0, 4'h0);
        cyc_low(4'h3);
        @(negedge clk);
        chk("R6 bank 0 number", bank_sel, 0);
        chk("R6 bank 0 passes ce", ce_out_n, 0);
        cyc_high(4'h3);
        unlock(1'b0, 4'hF);
        @(negedge clk);
        chk("R6 bank 15", bank_sel, 15);

        // R9: hold across ordinary cycles
        unlock(1'b0, 4'h9);
        for (int i = 0; i < 8; i++) cyc(4'((i * 7 + 3) % 16));
        @(negedge clk);
        chk("R9 bank held", bank_sel, 9);

        // R10: power-fail during a partial attempt
        cyc(4'hF);
        for (int i = 0; i < 6; i++) cyc(code[i]);
        @(posedge clk); #2 pfail = 1'b1;
        exp_bank = 4'h0; exp_off = 1'b1; hist.delete();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 bank cleared", bank_sel, 0);
        chk("R10 ce_out_n high", ce_out_n, 1);
        @(posedge clk); #2 pfail = 1'b0;
        for (int i = 6; i < 16; i++) cyc(step_nib(i, 1'b0, 4'h7));
        @(negedge clk);
        chk("R10 partial attempt discarded", bank_sel, 0);
        unlock(1'b0, 4'h7);
        @(negedge clk);
        chk("R10 unlock after power-fail", bank_sel, 7);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + c_chk, n_fail + c_fail);
        $finish;
    end
endmodule